// File: doc/BRIEF.md
# Serial EEPROM Pin-Sharing Port Arbiter

This block gives software a one-byte control register for driving a three-wire serial EEPROM by toggling bits ("bit-banging"). The EEPROM pins are shared with a memory port. Software asks for the pins by setting a request bit. The block hands them over only when the memory port reports that it is idle. Once the pins are handed over, the block switches them to the EEPROM and raises a ready bit at once. From then on, the chip-select, clock and data-out bits of the register drive the EEPROM pins directly, and the data-in bit shows the EEPROM output.

While the block owns the pins, the ready bit acts as a pacing timer. Every write that keeps the request set drops ready, and ready comes back after a fixed settle time. That time is given in nanoseconds and is turned into a cycle count from the clock period. Software can therefore poll ready between clock and data edges and never has to count time itself. Clearing the request bit hands the pins back to the memory port. Two more register bits pass an external arbitration request out of the block and show the matching acknowledge.

Top module: `seeprom_port_arb`

## Requirements
- R1: After a synchronous reset, every output is low, including all of `rd_data` and the pin-owner signal `ee_sel`.
- R2: A write with bit 5 (request) set while `mem_busy` is low grants the pins one cycle after the write. At grant, `ee_sel` goes high and ready (`rd_data` bit 4) goes high in the same cycle, with no settle delay.
- R3: While the block is waiting and `mem_busy` is high, it does not grant. Until grant, `ee_cs`, `ee_sk` and `ee_do` stay low.
- R4: While the pins are granted, `ee_cs`, `ee_sk` and `ee_do` follow the bits last written to positions 3, 2 and 1, from the cycle after the write.
- R5: `rd_data` bit 0 equals `ee_di` while the pins are granted, and is 0 otherwise.
- R6: While the pins are granted, a write with bit 5 set drops ready for exactly `SETTLE_CYC` cycles, which is ceil(`SETTLE_NS`/`CLK_PERIOD_NS`), 80 by default. Ready then rises again.
- R7: A write made while the settle timer is running restarts the full count.
- R8: A write with bit 5 clear releases the pins. From the next cycle, `ee_sel`, ready and all three EEPROM outputs are low.
- R9: Once the pins are granted, `mem_busy` has no effect on `ee_sel`, ready or the pins.
- R10: `rd_data` bits 5..1 read back the stored request, chip-select, clock and data-out bits (with bit 4 as ready). Bit 6 holds the last written external arbitration request and drives `ext_arb_req`. Bit 7 reads `ext_arb_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Control byte readback |
| mem_busy | input | 1 | Shared memory port is busy with another request |
| ext_arb_ack | input | 1 | External arbitration acknowledge |
| ext_arb_req | output | 1 | External arbitration request |
| ee_sel | output | 1 | High while the shared pins belong to the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data toward the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
Stored register bits, including the pin values, show up one clock after the write edge. The grant shows up one clock after the first cycle in which a pending request meets an idle `mem_busy`. Ready after a granted write stays low through edge `SETTLE_CYC`-1 and is high after edge `SETTLE_CYC`, counted from the write edge. Data-in and the external acknowledge pass straight through in the same cycle. The bench drives inputs on the falling edge and samples on a later falling edge. It checks ready both one cycle before and exactly at the expected rising edge, so a timer that is off by one cycle is caught.

// File: rtl/seeprom_arb_pkg.sv
package seeprom_arb_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_WAIT = 2'd1,
        OWN_EE   = 2'd2
    } own_state_t;

    // Bit order matters: software decodes it.
    typedef struct packed {
        logic ext_ack;
        logic ext_req;
        logic port_req;
        logic ready;
        logic cs;
        logic sk;
        logic dout;
        logic din;
    } ctrl_byte_t;

    function automatic int unsigned settle_cycles(input int unsigned ns,
                                                  input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/seeprom_owner_fsm.sv
module seeprom_owner_fsm
    import seeprom_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_req,
    input  logic       mem_busy,
    output own_state_t state,
    output logic       restart,
    output logic       release_now
);
    own_state_t state_q;

    assign release_now = wr_en && !wr_req;
    assign restart     = wr_en && wr_req && (state_q == OWN_EE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OWN_IDLE;
        end else if (release_now) begin
            state_q <= OWN_IDLE;
        end else begin
            case (state_q)
                OWN_IDLE: if (wr_en && wr_req) state_q <= OWN_WAIT;
                OWN_WAIT: if (!mem_busy)       state_q <= OWN_EE;
                OWN_EE:   state_q <= OWN_EE;
                default:  state_q <= OWN_IDLE;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/seeprom_settle_timer.sv
module seeprom_settle_timer #(
    parameter int unsigned CYCLES = 80,
    localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/seeprom_port_arb.sv
module seeprom_port_arb
    import seeprom_arb_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SETTLE_NS     = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       mem_busy,
    input  logic       ext_arb_ack,
    output logic       ext_arb_req,
    output logic       ee_sel,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_do,
    input  logic       ee_di
);
    localparam int unsigned SETTLE_CYC = settle_cycles(SETTLE_NS, CLK_PERIOD_NS);

    ctrl_byte_t  wr_byte;
    ctrl_byte_t  stored_q;
    ctrl_byte_t  view;
    own_state_t  own_state;
    logic        restart;
    logic        release_now;
    logic        timer_done;
    logic        owned;

    assign wr_byte = ctrl_byte_t'(wr_data);

    seeprom_owner_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_req     (wr_byte.port_req),
        .mem_busy   (mem_busy),
        .state      (own_state),
        .restart    (restart),
        .release_now(release_now)
    );

    seeprom_settle_timer #(.CYCLES(SETTLE_CYC)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .clear(release_now),
        .load (restart),
        .done (timer_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
        end else if (wr_en) begin
            stored_q.ext_req  <= wr_byte.ext_req;
            stored_q.port_req <= wr_byte.port_req;
            stored_q.cs       <= wr_byte.cs;
            stored_q.sk       <= wr_byte.sk;
            stored_q.dout     <= wr_byte.dout;
        end
    end

    assign owned = (own_state == OWN_EE);

    always_comb begin
        view         = stored_q;
        view.ext_ack = ext_arb_ack;
        view.ready   = owned && timer_done;
        view.din     = owned && ee_di;
    end

    assign rd_data     = view;
    assign ext_arb_req = stored_q.ext_req;
    assign ee_sel      = owned;
    assign ee_cs       = owned && stored_q.cs;
    assign ee_sk       = owned && stored_q.sk;
    assign ee_do       = owned && stored_q.dout;
endmodule

// File: rtl/seeprom_port_arb_chk.sv
module seeprom_port_arb_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       mem_busy,
    input logic       ext_arb_req,
    input logic       ee_sel,
    input logic       ee_cs,
    input logic       ee_sk,
    input logic       ee_do
);
    AST_PINS_LOW_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        !ee_sel |-> (!ee_cs && !ee_sk && !ee_do)); // R3

    AST_GRANT_ON_IDLE_MEM: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sel) |-> $past(!mem_busy)); // R2

    AST_GRANT_READY_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sel) |-> rd_data[4]); // R2

    AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[5] && ee_sel) |=> !rd_data[4]); // R6

    AST_RELEASE_PINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[5]) |=> (!ee_sel && !rd_data[4])); // R8

    AST_EXT_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ext_arb_req == $past(wr_data[6]))); // R10
endmodule

bind seeprom_port_arb seeprom_port_arb_chk i_chk (.*);

// File: tb/test_seeprom_port_arb.sv
module test_seeprom_port_arb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       mem_busy = 1'b0;
    logic       ext_arb_ack = 1'b0;
    logic       ext_arb_req;
    logic       ee_sel, ee_cs, ee_sk, ee_do;
    logic       ee_di = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    seeprom_port_arb i_seeprom_port_arb (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input logic ack, input logic xreq,
        input logic req, input logic rdy, input logic cs, input logic sk,
        input logic dout, input logic din);
        return {ack, xreq, req, rdy, cs, sk, dout, din};
    endfunction

    function automatic logic [3:0] exp_pins(input logic own, input logic [7:0] w);
        return own ? {1'b1, w[3], w[2], w[1]} : 4'b0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] w;
        void'($urandom(32'h5eed_0042));
        idle(3);
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pins", {ee_sel, ee_cs, ee_sk, ee_do, ext_arb_req}, 5'b0);
        rst = 1'b0;
        idle(1);
        check("R1 after reset", {rd_data, ee_sel}, 9'h0);

        // R3 busy memory port blocks grant; pins held low
        mem_busy = 1'b1;
        ee_di = 1'b1;
        write(8'h2D);
        idle(4);
        check("R3 no grant", {ee_sel, ee_cs, ee_sk, ee_do}, 4'b0);
        check("R5 din masked", rd_data, exp_byte(0, 0, 1, 0, 1, 1, 0, 0));

        // R2 grant with ready immediately
        mem_busy = 1'b0;
        idle(1);
        check("R2 granted", {ee_sel, rd_data[4]}, 2'b11);
        check("R4 pins", {ee_sel, ee_cs, ee_sk, ee_do}, exp_pins(1, 8'h2D));
        check("R5 din pass", rd_data[0], 1'b1);
        ee_di = 1'b0;
        #1 check("R5 din low", rd_data[0], 1'b0);

        // R9 mem_busy ignored once granted
        mem_busy = 1'b1;
        idle(3);
        check("R9 busy ignored", {ee_sel, rd_data[4], ee_cs}, 3'b111);

        // R6 pacing delay
        write(8'h2A);
        check("R4 pins after write", {ee_sel, ee_cs, ee_sk, ee_do}, exp_pins(1, 8'h2A));
        idle(SETTLE - 1);
        check("R6 ready low before", rd_data[4], 1'b0);
        idle(1);
        check("R6 ready high at count", rd_data[4], 1'b1);

        // R7 restart mid-count
        write(8'h28);
        idle(40);
        write(8'h2C);
        idle(SETTLE - 1);
        check("R7 still low", rd_data[4], 1'b0);
        idle(1);
        check("R7 ready high", rd_data[4], 1'b1);

        // R8 release
        write(8'h0E);
        check("R8 released", {ee_sel, rd_data[4], ee_cs, ee_sk, ee_do}, 5'b0);
        check("R10 readback", rd_data, exp_byte(0, 0, 0, 0, 1, 1, 1, 0));

        // R10 external arbitration bits
        ext_arb_ack = 1'b1;
        write(8'h40);
        check("R10 ext bits", {rd_data[7:6], ext_arb_req}, 3'b111);
        ext_arb_ack = 1'b0;
        #1 check("R10 ack low", rd_data[7], 1'b0);

        // Random writes while owned
        mem_busy = 1'b0;
        write(8'h20);
        idle(1);
        check("R2 regrant", {ee_sel, rd_data[4]}, 2'b11);
        for (int k = 0; k < 30; k++) begin
            w = 8'($urandom) | 8'h20;
            mem_busy = 1'($urandom);
            ee_di = 1'($urandom);
            write(w);
            check("R4 random pins", {ee_sel, ee_cs, ee_sk, ee_do}, exp_pins(1, w));
            check("R6 random ready", rd_data[6:0],
                  {w[6], 1'b1, 1'b0, w[3], w[2], w[1], ee_di});
            check("R9 random owned", ee_sel, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule